// File: doc/BRIEF.md
# Banked Interrupt Mask and Routing Register File

This block gathers seventy-two level-sensitive interrupt request lines and turns them into two processor-facing requests: a normal interrupt line and a fast interrupt line. The request lines are grouped into three banks of register bits. Two 32-bit banks are shared (lines 0 to 31 and 32 to 63), and one 8-bit bank is private to the processor (lines 64 to 71). Software reaches the block over a simple 32-bit register bus with a select, a write flag, a byte address and separate write-data and read-data buses.

Each line has one enable bit. Software turns enables on through set registers and off through separate clear registers. Writing a zero bit to either kind leaves the enable unchanged. The pending view shows the raw request levels, so a line stays pending until its peripheral drops the request. Software cannot clear it here. A routing register can steer one chosen line to the fast interrupt output. That line is then taken out of the normal interrupt.

Both outputs are registered. Read data is combinational from the current address and state.

Top module: `intc_banked`

## Requirements
- R1: After reset, every enable bit is 0, the routing register is 0 (fast routing off), and irqOut and fiqOut are 0.
- R2: Writing to word 4, 5 or 6 (byte address 0x10, 0x14, 0x18) sets the enables of shared bank 0, shared bank 1 or the private bank wherever the write data has a 1. Zero bits leave the enable unchanged. Private-bank writes use only data bits [7:0].
- R3: Writing to word 7, 8 or 9 (0x1C, 0x20, 0x24) clears the enables of bank 0, bank 1 or the private bank wherever the write data has a 1. Zero bits leave the enable unchanged.
- R4: Reading word 1, word 2 or word 0 (0x04, 0x08, 0x00) returns the current levels of lines 0–31, lines 32–63 or lines 64–71, in that order, with line n of a bank at bit n minus the bank base. Writes to these words change nothing.
- R5: Reading a set word or a clear word returns that bank's current enable mask. Bits above [7] of any private-bank read are 0.
- R6: irqOut in the cycle after an edge equals the OR, at that edge, over all lines of (level AND enable), leaving out the line currently routed to fast interrupt.
- R7: Word 3 (0x0C) holds the routing control. Bits [6:0] give the line number and bit 7 enables routing. It reads back with bits [31:8] at 0. fiqOut in the cycle after an edge is 1 exactly when, at that edge, routing was enabled, the number was below 72, and that line was high, whatever its enable bit.
- R8: Word addresses 10 to 15 read as 0 and ignore writes. Address bits [1:0] are ignored. busRdata is 0 whenever busSel is low or busWe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| src | input | 72 | Interrupt request levels, line n at bit n |
| busSel | input | 1 | Register access this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address; bits [5:2] pick the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address |
| irqOut | output | 1 | Registered normal interrupt request |
| fiqOut | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume a single-ported bus: one access per cycle, so a set and a clear of the same bank never land in the same cycle. They also assume the request levels are already synchronous to clk. They check enable changes one cycle after a write only against the data of that write. The stimulus changes every input at the falling edge and holds it through the next rising edge. It never drives more than one access per cycle, so it stays within these assumptions while still sweeping random levels, data and routing values, including line numbers of 72 and above.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_BANKS  = 3;
  localparam int NUM_SHARED = 2;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_PEND = 2'd1,
    RK_MASK = 2'd2,
    RK_FIQ  = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] setBank;
    logic [NUM_BANKS-1:0] clrBank;
    logic                 fiqWr;
    rdKind_e              rdKind;
    logic [1:0]           rdBank;
  } ctlStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        stb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic wrAcc, rdAcc;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrAcc   = busSel && busWe;
  assign rdAcc   = busSel && !busWe;

  always_comb begin
    stb        = '0;
    stb.rdKind = RK_NONE;
    case (wordIdx)
      IDX_W'(0): begin stb.rdBank = 2'd2; if (rdAcc) stb.rdKind = RK_PEND; end
      IDX_W'(1): begin stb.rdBank = 2'd0; if (rdAcc) stb.rdKind = RK_PEND; end
      IDX_W'(2): begin stb.rdBank = 2'd1; if (rdAcc) stb.rdKind = RK_PEND; end
      IDX_W'(3): begin
        stb.fiqWr = wrAcc;
        if (rdAcc) stb.rdKind = RK_FIQ;
      end
      IDX_W'(4): begin stb.rdBank = 2'd0; stb.setBank[0] = wrAcc; if (rdAcc) stb.rdKind = RK_MASK; end
      IDX_W'(5): begin stb.rdBank = 2'd1; stb.setBank[1] = wrAcc; if (rdAcc) stb.rdKind = RK_MASK; end
      IDX_W'(6): begin stb.rdBank = 2'd2; stb.setBank[2] = wrAcc; if (rdAcc) stb.rdKind = RK_MASK; end
      IDX_W'(7): begin stb.rdBank = 2'd0; stb.clrBank[0] = wrAcc; if (rdAcc) stb.rdKind = RK_MASK; end
      IDX_W'(8): begin stb.rdBank = 2'd1; stb.clrBank[1] = wrAcc; if (rdAcc) stb.rdKind = RK_MASK; end
      IDX_W'(9): begin stb.rdBank = 2'd2; stb.clrBank[2] = wrAcc; if (rdAcc) stb.rdKind = RK_MASK; end
      default: ;
    endcase
  end
endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CPU_SRC = 8,
  parameter int SEL_W   = 7
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctlStrobe_t                      stb,
  input  logic [DATA_W-1:0]               busWdata,
  input  logic [NUM_SHARED*DATA_W+CPU_SRC-1:0] src,
  output logic [DATA_W-1:0]               busRdata,
  output logic                            irqOut,
  output logic                            fiqOut,
  output logic [NUM_SHARED*DATA_W+CPU_SRC-1:0] enMask,
  output logic [SEL_W:0]                  fiqCtl
);
  localparam int NUM_SRC = NUM_SHARED * DATA_W + CPU_SRC;

  logic [DATA_W-1:0]  srcBank [0:3];
  logic [DATA_W-1:0]  enBank  [0:3];
  logic [NUM_SRC-1:0] fiqMask;
  logic               irqNext, fiqNext;

  // Per-bank enable storage; clear has priority over set
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W  = (b < NUM_SHARED) ? DATA_W : CPU_SRC;
    localparam int LO = b * DATA_W;
    logic [W-1:0] bankEn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 bankEn <= '0;
      else if (stb.clrBank[b])   bankEn <= bankEn & ~busWdata[W-1:0];
      else if (stb.setBank[b])   bankEn <= bankEn | busWdata[W-1:0];
    end

    assign enMask[LO +: W] = bankEn;
    assign srcBank[b]      = DATA_W'(src[LO +: W]);
    assign enBank[b]       = DATA_W'(bankEn);
  end
  assign srcBank[3] = '0;
  assign enBank[3]  = '0;

  // Fast routing control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          fiqCtl <= '0;
    else if (stb.fiqWr) fiqCtl <= busWdata[SEL_W:0];
  end

  // One-hot routing mask; numbers past the last line select nothing
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
    assign fiqMask[i] = fiqCtl[SEL_W] && (fiqCtl[SEL_W-1:0] == SEL_W'(i));
  end

  assign irqNext = |(src & enMask & ~fiqMask);
  assign fiqNext = |(src & fiqMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= irqNext;
      fiqOut <= fiqNext;
    end
  end

  // Read-back mux
  always_comb begin
    case (stb.rdKind)
      RK_PEND: busRdata = srcBank[stb.rdBank];
      RK_MASK: busRdata = enBank[stb.rdBank];
      RK_FIQ:  busRdata = DATA_W'(fiqCtl);
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_banked.sv
module intc_banked
  import intc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CPU_SRC = 8,
  parameter int ADDR_W  = 6,
  parameter int SEL_W   = 7
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_SHARED*DATA_W+CPU_SRC-1:0] src,
  input  logic                                 busSel,
  input  logic                                 busWe,
  input  logic [ADDR_W-1:0]                    busAddr,
  input  logic [DATA_W-1:0]                    busWdata,
  output logic [DATA_W-1:0]                    busRdata,
  output logic                                 irqOut,
  output logic                                 fiqOut
);
  localparam int NUM_SRC = NUM_SHARED * DATA_W + CPU_SRC;

  ctlStrobe_t         stb;
  logic [NUM_SRC-1:0] enMask;
  logic [SEL_W:0]     fiqCtl;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .stb    (stb)
  );

  intc_dp #(.DATA_W(DATA_W), .CPU_SRC(CPU_SRC), .SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busWdata(busWdata),
    .src     (src),
    .busRdata(busRdata),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut),
    .enMask  (enMask),
    .fiqCtl  (fiqCtl)
  );
endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk #(
  parameter int DATA_W  = 32,
  parameter int CPU_SRC = 8,
  parameter int ADDR_W  = 6,
  parameter int SEL_W   = 7,
  parameter int NUM_SRC = 72
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] src,
  input logic               busSel,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] enMask,
  input logic [SEL_W:0]     fiqCtl
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] wIdx;
  assign wIdx = busAddr[ADDR_W-1:2];

  // R2
  set_bank0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && wIdx == IDX_W'(4)) |=>
      ((enMask[DATA_W-1:0] & $past(busWdata)) == $past(busWdata)));

  // R3
  clr_bank0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && wIdx == IDX_W'(7)) |=>
      ((enMask[DATA_W-1:0] & $past(busWdata)) == '0));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWe) |=> ($stable(enMask) && $stable(fiqCtl)));

  // R4
  pend_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && wIdx == IDX_W'(1)) |-> (busRdata == src[DATA_W-1:0]));

  // R5
  cpu_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && (wIdx == IDX_W'(0) || wIdx == IDX_W'(6) || wIdx == IDX_W'(9)))
      |-> (busRdata[DATA_W-1:CPU_SRC] == '0));

  // R6
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (src == '0) |=> (!irqOut && !fiqOut));

  // R7
  fiq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fiqCtl[SEL_W] |=> !fiqOut);
endmodule

bind intc_banked intc_banked_chk #(
  .DATA_W(DATA_W), .CPU_SRC(CPU_SRC), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
  .NUM_SRC(NUM_SRC)
) u_chk (
  .clk(clk), .rstN(rstN), .src(src), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .irqOut(irqOut), .fiqOut(fiqOut), .enMask(enMask), .fiqCtl(fiqCtl)
);

// File: tb/intc_banked_tb.sv
`timescale 1ns/1ps
module intc_banked_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [71:0] src = '0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  bit [71:0] mEn;
  bit [7:0]  mFiq;
  bit        mIrq, mFiqO;

  always #2 clk = ~clk;

  intc_banked u_dut (
    .clk(clk), .rstN(rstN), .src(src), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRd();
    if (!busSel || busWe) return 32'h0;
    case (busAddr[5:2])
      4'd0: return {24'h0, src[71:64]};
      4'd1: return src[31:0];
      4'd2: return src[63:32];
      4'd3: return {24'h0, mFiq};
      4'd4, 4'd7: return mEn[31:0];
      4'd5, 4'd8: return mEn[63:32];
      4'd6, 4'd9: return {24'h0, mEn[71:64]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rdTag();
    if (!busSel || busWe) return "R8";
    case (busAddr[5:2])
      4'd0, 4'd1, 4'd2: return "R4";
      4'd3: return "R7";
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R5";
      default: return "R8";
    endcase
  endfunction

  // advance model at the rising edge, compare at the falling edge
  task automatic step();
    bit nIrq, nFiq;
    int sel;
    @(posedge clk);
    if (!rstN) begin
      mEn = '0; mFiq = '0; mIrq = 0; mFiqO = 0;
    end else begin
      sel = int'(mFiq[6:0]);
      nIrq = 0;
      for (int i = 0; i < 72; i++)
        if (src[i] && mEn[i] && !(mFiq[7] && sel == i)) nIrq = 1;
      nFiq = mFiq[7] && sel < 72 && src[sel];
      mIrq = nIrq; mFiqO = nFiq;
      if (busSel && busWe) begin
        case (busAddr[5:2])
          4'd3: mFiq = busWdata[7:0];
          4'd4: mEn[31:0]  = mEn[31:0]  | busWdata;
          4'd5: mEn[63:32] = mEn[63:32] | busWdata;
          4'd6: mEn[71:64] = mEn[71:64] | busWdata[7:0];
          4'd7: mEn[31:0]  = mEn[31:0]  & ~busWdata;
          4'd8: mEn[63:32] = mEn[63:32] & ~busWdata;
          4'd9: mEn[71:64] = mEn[71:64] & ~busWdata[7:0];
          default: ;
        endcase
      end
    end
    @(negedge clk);
    if (rstN) begin
      check("R6 irqOut", 32'(irqOut), 32'(mIrq));
      check("R7 fiqOut", 32'(fiqOut), 32'(mFiqO));
      check({rdTag(), " busRdata"}, busRdata, expRd());
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    step();
    busSel = 0; busWe = 0;
  endtask

  task automatic rd(logic [5:0] a);
    busSel = 1; busWe = 0; busAddr = a; busWdata = $urandom;
    step();
    busSel = 0;
  endtask

  task automatic readAll();
    for (int w = 0; w < 16; w++) rd(6'(w * 4));
  endtask

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    // R1: reset state
    check("R1 irqOut", 32'(irqOut), 32'h0);
    check("R1 fiqOut", 32'(fiqOut), 32'h0);
    rd(6'h10); check("R1 enable0", busRdata, 32'h0);
    rd(6'h0C); check("R1 route", busRdata, 32'h0);
    src = '1; step(); step();
    check("R1 no irq with all disabled", 32'(irqOut), 32'h0);
    readAll();

    // R2: set registers, zero bits keep state
    wr(6'h10, 32'h0000_0202);
    wr(6'h10, 32'h0);
    rd(6'h10); check("R2 set keeps bits", busRdata, 32'h0000_0202);
    wr(6'h14, 32'h8000_0001);
    wr(6'h18, 32'hFFFF_FF81);
    rd(6'h18); check("R2 private width", busRdata, 32'h0000_0081);

    // R3: clear registers
    wr(6'h1C, 32'h0000_0002);
    wr(6'h20, 32'h0);
    rd(6'h1C); check("R3 clear one bit", busRdata, 32'h0000_0200);
    rd(6'h20); check("R3 zero clear no effect", busRdata, 32'h8000_0001);
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24); check("R3 private cleared", busRdata, 32'h0);

    // R4: pending view, writes ignored
    src = 72'hA5_0123_4567_89AB_CDEF;
    wr(6'h04, 32'hFFFF_FFFF); wr(6'h00, 32'h0); wr(6'h08, 32'h1234);
    rd(6'h04); check("R4 pend bank0", busRdata, 32'h89AB_CDEF);
    rd(6'h08); check("R4 pend bank1", busRdata, 32'h0123_4567);
    rd(6'h00); check("R4 pend private", busRdata, 32'h0000_00A5);
    rd(6'h10); check("R4 write to pending ignored", busRdata, 32'h0000_0200);

    // R6: single enabled line drives irq
    src = '0; step();
    src[9] = 1; step(); step();
    check("R6 irq from line 9", 32'(irqOut), 32'h1);
    src[9] = 0; step(); step();
    check("R6 irq drops with level", 32'(irqOut), 32'h0);

    // R7: routing
    src = '0; src[9] = 1; src[70] = 1;
    wr(6'h0C, 32'h0000_0089);
    rd(6'h0C); check("R7 route readback", busRdata, 32'h0000_0089);
    step();
    check("R7 routed line on fiq", 32'(fiqOut), 32'h1);
    check("R7 routed line off irq", 32'(irqOut), 32'h0);
    wr(6'h0C, 32'hFFFF_FFC6); step();
    check("R7 line 70 fiq without enable", 32'(fiqOut), 32'h1);
    wr(6'h0C, 32'h0000_00C8); step();
    check("R7 number 72 selects none", 32'(fiqOut), 32'h0);
    wr(6'h0C, 32'h0000_0046); step();
    check("R7 routing off", 32'(fiqOut), 32'h0);

    // R8: unmapped words and byte-offset bits
    for (int w = 10; w < 16; w++) wr(6'(w * 4), 32'hFFFF_FFFF);
    readAll();
    wr(6'h13, 32'h0000_0400);
    rd(6'h11); check("R8 low address bits ignored", busRdata, 32'h0000_0600);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(3) == 0) src = {8'($urandom), $urandom, $urandom};
      busSel = $urandom_range(1);
      busWe = $urandom_range(1);
      busAddr = 6'($urandom);
      busWdata = ($urandom_range(1) != 0) ? $urandom : ($urandom & $urandom & $urandom);
      step();
    end
    busSel = 0;

    // reset again in mid-state
    rstN = 0; step(); rstN = 1; step();
    check("R1 irq after reset", 32'(irqOut), 32'h0);
    rd(6'h14); check("R1 enables after reset", busRdata, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule